// File: doc/BRIEF.md
# Tick Timer Peripheral

This block is a 32-bit timer peripheral behind a plain synchronous register port. It holds a free-running timestamp counter and two down-counting event timers. Each event timer is programmed through a single reload word whose two low bits act as controls: an enable bit and a one-shot select. The remaining bits give the period, and the bottom two bits of that period are always taken as zero.

A periodic timer raises its pending flag every period and reloads by itself. A one-shot timer raises its flag once, clears its own enable bit and stops. Pending flags are collected in a status word that software clears by writing ones. An interrupt line follows the two event-timer flags. Timestamp wrap-around sets a third flag, which does not drive the interrupt line.

Register map (byte offsets, one 32-bit word each): 0x00 timestamp, 0x04 timer 1 count, 0x08 timer 1 reload, 0x0C timer 2 count, 0x10 timer 2 reload, 0x20 status. Any other offset reads zero and ignores writes.

Top module: `tt_timer_top`

## Requirements
- R1: While reset is held, every register reads 0 and irq is low.
- R2: The timestamp at offset 0x00 goes up by one every clock. A write to 0x00 loads the written value, and counting continues from that value. A read returns the current value.
- R3: When the timestamp steps from 0xFFFFFFFF to 0 without a write in that clock, status bit 2 becomes 1.
- R4: A reload write (0x08 for timer 1, 0x10 for timer 2) stores the whole word, with bit 0 as enable and bit 1 as one-shot. In the same clock it loads the count register (0x04 or 0x0C) with the written value ANDed with 0xFFFFFFFC.
- R5: An enabled timer lowers its count by one each clock. A disabled timer holds its count.
- R6: In periodic mode with period P, the pending bit (status bit 0 for timer 1, bit 1 for timer 2) becomes 1 on the P-th clock after the reload write. The count is reloaded with P on that clock, and the same happens every P clocks after that.
- R7: In one-shot mode the pending bit is set once. In the same clock the enable bit reads back as 0 and the count becomes 0, and no further event follows.
- R8: Writing zero to a reload register stops the timer and clears its count.
- R9: Writing a 1 to a status bit clears it and writing a 0 leaves it. Status bit 3 always reads 0. Writes to the count registers are ignored.
- R10: irq is the OR of status bits 0 and 1. Status bit 2 does not drive irq.
- R11: If a clear of a pending bit and a new expiry of that timer land in the same clock, the bit stays 1.
- R12: Rewriting a running timer's reload word with a new period restarts the count from the new period. The next event comes after the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, high while a timer event is pending |

## Verification
The timers are driven with:
- a periodic period of 8, which separates off-by-one expiry from correct expiry and shows the automatic reload;
- a one-shot period of 4 on the second timer, which shows the self-disable and that no second event follows;
- a reload word with nonzero low value bits, which shows the masking;
- a mid-count period change, which shows whether the new period is used at once.

A status clear timed onto an expiry clock separates a clear-wins design from a set-wins design. A timestamp preset just below wrap-around shows whether the wrap flag is raised and kept off the interrupt line.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_EVT  = 2;
    localparam int unsigned ST_W     = 4;

    localparam int unsigned OFF_TS       = 'h00;
    localparam int unsigned OFF_CNT_BASE = 'h04;
    localparam int unsigned OFF_RLD_BASE = 'h08;
    localparam int unsigned OFF_STRIDE   = 'h08;
    localparam int unsigned OFF_STATUS   = 'h20;

    localparam int unsigned ST_BIT_TS = 2;

    typedef struct packed {
        logic [DATA_W-3:0] value;
        logic              oneshot;
        logic              enable;
    } reload_t;

    function automatic int unsigned count_off(input int unsigned idx);
        return OFF_CNT_BASE + OFF_STRIDE * idx;
    endfunction

    function automatic int unsigned reload_off(input int unsigned idx);
        return OFF_RLD_BASE + OFF_STRIDE * idx;
    endfunction

    function automatic logic [DATA_W-1:0] period_of(input reload_t r);
        return {r.value, 2'b00};
    endfunction
endpackage

// File: rtl/tt_tstamp.sv
module tt_tstamp
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ts_q,
    output logic              wrap
);
    always_comb wrap = !wr && (ts_q == '1);

    always_ff @(posedge clk) begin
        if (rst)
            ts_q <= '0;
        else if (wr)
            ts_q <= wdata;
        else
            ts_q <= ts_q + 1'b1;
    end
endmodule

// File: rtl/tt_evt_timer.sv
module tt_evt_timer
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_wr,
    input  logic [DATA_W-1:0] wdata,
    output reload_t           reload_q,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);
    // expiry on the clock that would take the count from 1 to 0
    always_comb expire = reload_q.enable && (count_q <= DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
        end else if (reload_wr) begin
            reload_q <= reload_t'(wdata);
            count_q  <= {wdata[DATA_W-1:2], 2'b00};
        end else if (expire) begin
            if (reload_q.oneshot) begin
                reload_q.enable <= 1'b0;
                count_q         <= '0;
            end else begin
                count_q <= period_of(reload_q);
            end
        end else if (reload_q.enable) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/tt_status.sv
module tt_status
    import tt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] set_vec,
    output logic [ST_W-1:0] pend_q
);
    logic [ST_W-1:0] clr_eff;

    always_comb clr_eff = clr_wr ? clr_mask : '0;

    // a set in the same clock wins over a clear
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_eff) | set_vec;
    end
endmodule

// File: rtl/tt_timer_top.sv
module tt_timer_top
    import tt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0]  ts_q;
    logic               ts_wr;
    logic               ts_wrap;
    logic               st_wr;
    logic [ST_W-1:0]    pend;
    logic [ST_W-1:0]    st_set;

    reload_t            rl_q  [NUM_EVT];
    logic [DATA_W-1:0]  cnt_q [NUM_EVT];
    logic [NUM_EVT-1:0] expire;
    logic [NUM_EVT-1:0] rl_wr;
    logic [NUM_EVT-1:0] en_v;
    logic [NUM_EVT-1:0] os_v;

    assign ts_wr = bus_we && (bus_addr == ADDR_W'(OFF_TS));
    assign st_wr = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));

    tt_tstamp u_ts (
        .clk  (clk),
        .rst  (rst),
        .wr   (ts_wr),
        .wdata(bus_wdata),
        .ts_q (ts_q),
        .wrap (ts_wrap)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        assign rl_wr[g] = bus_we && (bus_addr == ADDR_W'(reload_off(g)));
        assign en_v[g]  = rl_q[g].enable;
        assign os_v[g]  = rl_q[g].oneshot;

        tt_evt_timer u_evt (
            .clk      (clk),
            .rst      (rst),
            .reload_wr(rl_wr[g]),
            .wdata    (bus_wdata),
            .reload_q (rl_q[g]),
            .count_q  (cnt_q[g]),
            .expire   (expire[g])
        );
    end

    always_comb begin
        st_set            = '0;
        st_set[NUM_EVT-1:0] = expire;
        st_set[ST_BIT_TS] = ts_wrap;
    end

    tt_status u_st (
        .clk     (clk),
        .rst     (rst),
        .clr_wr  (st_wr),
        .clr_mask(bus_wdata[ST_W-1:0]),
        .set_vec (st_set),
        .pend_q  (pend)
    );

    assign irq = |pend[NUM_EVT-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_TS))
            bus_rdata = ts_q;
        if (bus_addr == ADDR_W'(OFF_STATUS))
            bus_rdata = {{(DATA_W-ST_W){1'b0}}, pend};
        for (int i = 0; i < NUM_EVT; i++) begin
            if (bus_addr == ADDR_W'(count_off(i)))
                bus_rdata = cnt_q[i];
            if (bus_addr == ADDR_W'(reload_off(i)))
                bus_rdata = rl_q[i];
        end
    end
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk
    import tt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  ts_q,
    input logic               ts_wr,
    input logic [ST_W-1:0]    pend,
    input logic               st_wr,
    input logic [ST_W-1:0]    st_wdata,
    input logic [NUM_EVT-1:0] expire,
    input logic [NUM_EVT-1:0] en_v,
    input logic [NUM_EVT-1:0] os_v,
    input logic [NUM_EVT-1:0] rl_wr,
    input logic [DATA_W-1:0]  cnt0
);
    p_ts_count_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ts_wr)) |-> ts_q == $past(ts_q) + 1'b1);

    p_ts_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ts_q == '1 && !ts_wr) |=> pend[ST_BIT_TS]);

    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        (en_v[0] && !expire[0] && !rl_wr[0]) |=> cnt0 == $past(cnt0) - 1'b1);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt_chk
        p_expire_pend_r6: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> pend[i]);

        p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
            (expire[i] && os_v[i] && !rl_wr[i]) |=> !en_v[i]);
    end

    for (genvar b = 0; b < ST_W - 1; b++) begin : g_st_chk
        p_sticky_pend_r9: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(pend[b]) && !($past(st_wr) && $past(st_wdata[b])))
            |-> pend[b]);
    end

    p_no_wd_pend_r9: assert property (@(posedge clk) disable iff (rst)
        !pend[3]);
endmodule

bind tt_timer_top tt_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ts_q    (ts_q),
    .ts_wr   (ts_wr),
    .pend    (pend),
    .st_wr   (st_wr),
    .st_wdata(bus_wdata[3:0]),
    .expire  (expire),
    .en_v    (en_v),
    .os_v    (os_v),
    .rl_wr   (rl_wr),
    .cnt0    (cnt_q[0])
);

// File: tb/sim_tt_timer_top.sv
module sim_tt_timer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tt_timer_top u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (addr),
        .bus_we   (we),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic t_reset;
        idle(3);
        chk_reg("R1 ts", 8'h00, 0);
        chk_reg("R1 cnt1", 8'h04, 0);
        chk_reg("R1 rld1", 8'h08, 0);
        chk_reg("R1 cnt2", 8'h0C, 0);
        chk_reg("R1 rld2", 8'h10, 0);
        chk_reg("R1 status", 8'h20, 0);
        check("R1 irq", {31'b0, irq}, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_tstamp;
        wr(8'h00, 32'd100);
        chk_reg("R2 load", 8'h00, 32'd100);
        idle(5);
        chk_reg("R2 count", 8'h00, 32'd105);
    endtask

    task automatic t_wrap;
        wr(8'h20, 32'hF);
        wr(8'h00, 32'hFFFF_FFFE);
        idle(1);
        chk_reg("R3 before wrap ts", 8'h00, 32'hFFFF_FFFF);
        chk_reg("R3 before wrap status", 8'h20, 0);
        idle(1);
        chk_reg("R3 wrapped ts", 8'h00, 0);
        chk_reg("R3 status bit2", 8'h20, 32'h4);
        check("R10 wrap not on irq", {31'b0, irq}, 0);
        wr(8'h20, 32'h4);
        chk_reg("R9 clear bit2", 8'h20, 0);
    endtask

    task automatic t_periodic;
        wr(8'h08, 32'd9);
        chk_reg("R4 count load", 8'h04, 32'd8);
        chk_reg("R4 reload readback", 8'h08, 32'd9);
        idle(7);
        chk_reg("R5 count near end", 8'h04, 32'd1);
        chk_reg("R6 not yet pending", 8'h20, 0);
        idle(1);
        chk_reg("R6 pending", 8'h20, 32'h1);
        chk_reg("R6 reloaded", 8'h04, 32'd8);
        check("R10 irq t1", {31'b0, irq}, 1);
        idle(8);
        chk_reg("R6 second reload", 8'h04, 32'd8);
        wr(8'h20, 32'h1);
        chk_reg("R9 cleared", 8'h20, 0);
        check("R10 irq low", {31'b0, irq}, 0);
        idle(6);
        chk_reg("R6 before next", 8'h20, 0);
        idle(1);
        chk_reg("R6 next event", 8'h20, 32'h1);
        wr(8'h08, 0);
        wr(8'h20, 32'h1);
    endtask

    task automatic t_oneshot;
        wr(8'h10, 32'd7);
        chk_reg("R4 t2 count", 8'h0C, 32'd4);
        idle(3);
        chk_reg("R7 t2 not yet", 8'h20, 0);
        idle(1);
        chk_reg("R7 t2 pending", 8'h20, 32'h2);
        check("R10 irq t2", {31'b0, irq}, 1);
        chk_reg("R7 enable cleared", 8'h10, 32'd6);
        chk_reg("R7 count zero", 8'h0C, 0);
        wr(8'h20, 32'h2);
        idle(10);
        chk_reg("R7 no second event", 8'h20, 0);
        chk_reg("R7 count stays", 8'h0C, 0);
        wr(8'h10, 0);
    endtask

    task automatic t_disable;
        wr(8'h08, 32'h11);
        chk_reg("R4 low bits masked", 8'h04, 32'd16);
        chk_reg("R4 readback raw", 8'h08, 32'h11);
        idle(3);
        chk_reg("R5 decrement", 8'h04, 32'd13);
        wr(8'h08, 0);
        chk_reg("R8 count cleared", 8'h04, 0);
        chk_reg("R8 reload cleared", 8'h08, 0);
        idle(20);
        chk_reg("R8 stays idle", 8'h04, 0);
        chk_reg("R8 no event", 8'h20, 0);
        wr(8'h08, 32'h20);
        idle(5);
        chk_reg("R5 disabled holds", 8'h04, 32'd32);
        wr(8'h04, 32'd123);
        chk_reg("R9 count write ignored", 8'h04, 32'd32);
        wr(8'h20, 32'hFFFF_FFFF);
        chk_reg("R9 bit3 zero", 8'h20, 0);
        wr(8'h08, 0);
    endtask

    task automatic t_collide;
        wr(8'h08, 32'd5);
        idle(3);
        chk_reg("R11 count one", 8'h04, 32'd1);
        wr(8'h20, 32'h1);
        chk_reg("R11 set wins", 8'h20, 32'h1);
        wr(8'h20, 32'h1);
        chk_reg("R11 later clear", 8'h20, 0);
        wr(8'h08, 0);
    endtask

    task automatic t_retarget;
        wr(8'h08, 32'd9);
        idle(2);
        chk_reg("R12 running", 8'h04, 32'd6);
        wr(8'h08, 32'd21);
        chk_reg("R12 new count", 8'h04, 32'd20);
        chk_reg("R12 mode kept", 8'h08, 32'd21);
        idle(19);
        chk_reg("R12 not yet", 8'h20, 0);
        idle(1);
        chk_reg("R12 event", 8'h20, 32'h1);
        chk_reg("R12 reload new", 8'h04, 32'd20);
        wr(8'h08, 0);
        wr(8'h20, 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_tstamp();
        t_wrap();
        t_periodic();
        t_oneshot();
        t_disable();
        t_collide();
        t_retarget();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule